// File: doc/BRIEF.md
# Card Interrupt Status and Enable Registers

This block gathers the interrupt sources of a bus-interface card into one host interrupt line. Three sources feed it: a live interrupt request from the bus-controller chip, and two one-cycle pulses from the transfer engine, one marking that the end of a buffer was reached and one marking that the transfer count ran out. The two engine pulses are captured in sticky status bits, but only while the matching event-enable bit is set. The controller request is not captured; the status register shows it as it is.

Host software sets the event-enable, interrupt-enable and card-mode registers through a simple synchronous register port. It reads the status register to find out why the card interrupted, and it clears the sticky engine bits by writing ones to them. The card-mode register holds a global interrupt enable and a system-controller select output, and it reports a live active-controller input. A write-only timing register holds a bus delay, counted in 30 ns clock units, for the bus logic next to this block.

Top module: `evt_irq_regs`

## Requirements
- R1: After a synchronous reset, every stored register is 0: card mode, interrupt enable, event enable, the delay and both sticky events. `host_irq`, `sys_ctrl_sel` and `reg_rdata` are 0.
- R2: Status bit 4 (buffer end) and status bit 5 (terminal count) are set by their pulse only when the same bit in the event-enable register (address 0x05) is 1. A pulse that arrives while that enable bit is 0 leaves the status bit at 0.
- R3: A write to the status register (address 0x04) clears each of bits 4 and 5 that has a 1 in the written data. A 0 in the written data leaves that bit unchanged.
- R4: When an enabled event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 0 reads the live `chip_irq` input, and status bit 1 reads the current `host_irq` output. Writes to bits 0 and 1 have no effect.
- R6: In the cycle after any clock edge, `host_irq` equals GIE AND ((`chip_irq` AND interrupt-enable bit 0) OR (sticky buffer end AND interrupt-enable bit 4) OR (sticky terminal count AND interrupt-enable bit 5)). All of these values are the ones present before that edge. The interrupt-enable register is at address 0x03.
- R7: While the global interrupt enable (card-mode bit 5) is 0, `host_irq` stays 0, whatever sources are pending.
- R8: The card-mode register at address 0x01 stores only bit 5 (GIE) and bit 3 (system-controller select, driven on `sys_ctrl_sel`). Its bit 1 reads the live `active_ctrl_in` input. In the card-mode, interrupt-enable and event-enable registers, any bit not defined above reads 0.
- R9: A write to address 0x19 loads `bus_delay` with the written value. This value is a count of 30 ns clock units in the range 0 to 255. A read of address 0x19 returns 0, and so does a read of any address not defined above.
- R10: `reg_rdata` shows the register selected by `reg_addr` one clock after the address is presented. It reflects the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| chip_irq | input | 1 | Live interrupt request from the bus-controller chip |
| bufend_pulse | input | 1 | One-cycle buffer-end event from the transfer engine |
| tcount_pulse | input | 1 | One-cycle terminal-count event from the transfer engine |
| active_ctrl_in | input | 1 | Live active-controller indication |
| host_irq | output | 1 | Registered host interrupt request |
| sys_ctrl_sel | output | 1 | System-controller select |
| bus_delay | output | DLY_W | Bus delay in 30 ns clock units |

## Verification
The interrupt path is driven by each source on its own: the controller request alone, buffer end alone, and a terminal count left pending while its interrupt enable is off. This separates the three AND terms of the summary and shows that a wrong enable bit is not used. Event pulses are sent both with and without their event enable, which shows that the event enable gates capture and not only the interrupt. Clearing writes are tried with all-zero data, with a single one, with ones only in the read-only bits, and in the same cycle as a new pulse. These cases separate write-one-to-clear from plain overwrite and show which wins a same-cycle conflict. Every register is also written with all ones, which exposes any bit that should not be stored.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  // register offsets
  localparam int OFS_CARD_MODE = 'h01;
  localparam int OFS_IRQ_EN    = 'h03;
  localparam int OFS_STATUS    = 'h04;
  localparam int OFS_EVT_EN    = 'h05;
  localparam int OFS_DELAY     = 'h19;

  // number of latched engine events: index 0 = buffer end, 1 = terminal count
  localparam int NUM_EVT = 2;

  // bit positions
  localparam int BIT_CHIP     = 0;  // status / irq enable: controller request
  localparam int BIT_SUMMARY  = 1;  // status: host interrupt asserted
  localparam int BIT_EVT_BASE = 4;  // first engine event bit
  localparam int BIT_GIE      = 5;  // card mode: global interrupt enable
  localparam int BIT_SYSCTL   = 3;  // card mode: system-controller select
  localparam int BIT_ACTCTL   = 1;  // card mode: active-controller (read only)

  function automatic int evt_bit(input int idx);
    return BIT_EVT_BASE + idx;
  endfunction
endpackage

// File: rtl/eirq_cfg_regs.sv
module eirq_cfg_regs
  import eirq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               gie,
  output logic               sysctl,
  output logic               ie_chip,
  output logic [NUM_EVT-1:0] ie_evt,
  output logic [NUM_EVT-1:0] ee_evt,
  output logic [DLY_W-1:0]   dly
);
  logic hit_cm, hit_ie, hit_ee, hit_dly;
  logic [DLY_W-1:0] dly_next;

  assign hit_cm  = wr && (addr == ADDR_W'(OFS_CARD_MODE));
  assign hit_ie  = wr && (addr == ADDR_W'(OFS_IRQ_EN));
  assign hit_ee  = wr && (addr == ADDR_W'(OFS_EVT_EN));
  assign hit_dly = wr && (addr == ADDR_W'(OFS_DELAY));

  // delay register narrower than the bus saturates; otherwise zero-extends
  generate
    if (DLY_W >= DATA_W) begin : g_dly_wide
      assign dly_next = DLY_W'(wdata);
    end else begin : g_dly_sat
      assign dly_next = (|wdata[DATA_W-1:DLY_W]) ? {DLY_W{1'b1}}
                                                 : wdata[DLY_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      gie    <= 1'b0;
      sysctl <= 1'b0;
    end else if (hit_cm) begin
      gie    <= wdata[BIT_GIE];
      sysctl <= wdata[BIT_SYSCTL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ie_chip <= 1'b0;
    else if (hit_ie) ie_chip <= wdata[BIT_CHIP];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVT; gi++) begin : g_en
      always_ff @(posedge clk) begin
        if (rst) begin
          ie_evt[gi] <= 1'b0;
          ee_evt[gi] <= 1'b0;
        end else begin
          if (hit_ie) ie_evt[gi] <= wdata[evt_bit(gi)];
          if (hit_ee) ee_evt[gi] <= wdata[evt_bit(gi)];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dly <= '0;
    else if (hit_dly) dly <= dly_next;
  end
endmodule

// File: rtl/eirq_evt_latch.sv
module eirq_evt_latch (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic arm,
  input  logic clr,
  output logic q
);
  // an armed pulse outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)               q <= 1'b0;
    else if (pulse && arm) q <= 1'b1;
    else if (clr)          q <= 1'b0;
  end
endmodule

// File: rtl/eirq_summary.sv
module eirq_summary #(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gie,
  input  logic               chip_irq,
  input  logic               ie_chip,
  input  logic [NUM_EVT-1:0] evt_q,
  input  logic [NUM_EVT-1:0] ie_evt,
  output logic               irq_q
);
  logic any_src;
  assign any_src = (chip_irq && ie_chip) || (|(evt_q & ie_evt));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie && any_src;
  end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import eirq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              chip_irq,
  input  logic              bufend_pulse,
  input  logic              tcount_pulse,
  input  logic              active_ctrl_in,
  output logic              host_irq,
  output logic              sys_ctrl_sel,
  output logic [DLY_W-1:0]  bus_delay
);
  logic               cm_gie;
  logic               ie_chip;
  logic [NUM_EVT-1:0] ie_evt;
  logic [NUM_EVT-1:0] ee_evt;
  logic [NUM_EVT-1:0] evt_pulse;
  logic [NUM_EVT-1:0] evt_q;
  logic               st_wr;
  logic [DATA_W-1:0]  rd_next;

  assign evt_pulse = {tcount_pulse, bufend_pulse};
  assign st_wr     = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));

  eirq_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .gie(cm_gie), .sysctl(sys_ctrl_sel), .ie_chip(ie_chip),
    .ie_evt(ie_evt), .ee_evt(ee_evt), .dly(bus_delay)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVT; gi++) begin : g_evt
      eirq_evt_latch u_lat (
        .clk(clk), .rst(rst), .pulse(evt_pulse[gi]), .arm(ee_evt[gi]),
        .clr(st_wr && reg_wdata[evt_bit(gi)]), .q(evt_q[gi])
      );
    end
  endgenerate

  eirq_summary #(.NUM_EVT(NUM_EVT)) u_sum (
    .clk(clk), .rst(rst), .gie(cm_gie), .chip_irq(chip_irq),
    .ie_chip(ie_chip), .evt_q(evt_q), .ie_evt(ie_evt), .irq_q(host_irq)
  );

  // read multiplexer, registered
  always_comb begin
    rd_next = '0;
    case (reg_addr)
      ADDR_W'(OFS_CARD_MODE): begin
        rd_next[BIT_GIE]    = cm_gie;
        rd_next[BIT_SYSCTL] = sys_ctrl_sel;
        rd_next[BIT_ACTCTL] = active_ctrl_in;
      end
      ADDR_W'(OFS_IRQ_EN): begin
        rd_next[BIT_CHIP] = ie_chip;
        for (int i = 0; i < NUM_EVT; i++) rd_next[evt_bit(i)] = ie_evt[i];
      end
      ADDR_W'(OFS_EVT_EN): begin
        for (int i = 0; i < NUM_EVT; i++) rd_next[evt_bit(i)] = ee_evt[i];
      end
      ADDR_W'(OFS_STATUS): begin
        rd_next[BIT_CHIP]    = chip_irq;
        rd_next[BIT_SUMMARY] = host_irq;
        for (int i = 0; i < NUM_EVT; i++) rd_next[evt_bit(i)] = evt_q[i];
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               chip_irq,
  input logic               host_irq,
  input logic               cm_gie,
  input logic               ie_chip,
  input logic [NUM_EVT-1:0] ee_evt,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic [NUM_EVT-1:0] evt_q
);
  // R1: reset leaves the interrupt line low
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !host_irq);

  // R7: no interrupt without the global enable
  a_r7_gie_off: assert property (@(posedge clk) disable iff (rst)
    !cm_gie |=> !host_irq);

  // R6: an enabled controller request raises the line next cycle
  a_r6_chip_path: assert property (@(posedge clk) disable iff (rst)
    (cm_gie && ie_chip && chip_irq) |=> host_irq);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVT; gi++) begin : g_chk
      // R2: a disabled event is never captured
      a_r2_gated: assert property (@(posedge clk) disable iff (rst)
        (!evt_q[gi] && !ee_evt[gi]) |=> !evt_q[gi]);
      // R4: an armed pulse always leaves the bit set
      a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[gi] && ee_evt[gi]) |=> evt_q[gi]);
      // R3: a one written to the bit clears it when no armed pulse competes
      a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(OFS_STATUS) && reg_wdata[evt_bit(gi)]
         && !(evt_pulse[gi] && ee_evt[gi])) |=> !evt_q[gi]);
    end
  endgenerate
endmodule

bind evt_irq_regs eirq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .chip_irq(chip_irq), .host_irq(host_irq),
  .cm_gie(cm_gie), .ie_chip(ie_chip), .ee_evt(ee_evt),
  .evt_pulse(evt_pulse), .evt_q(evt_q)
);

// File: tb/evt_irq_regs_tb.sv
`timescale 1ns/1ps
module evt_irq_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       chip_irq = 1'b0;
  logic       bufend_pulse = 1'b0;
  logic       tcount_pulse = 1'b0;
  logic       active_ctrl_in = 1'b0;
  logic       host_irq;
  logic       sys_ctrl_sel;
  logic [7:0] bus_delay;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_irq_regs u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chip_irq(chip_irq),
    .bufend_pulse(bufend_pulse), .tcount_pulse(tcount_pulse),
    .active_ctrl_in(active_ctrl_in), .host_irq(host_irq),
    .sys_ctrl_sel(sys_ctrl_sel), .bus_delay(bus_delay)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cm, m_ie, m_ee, m_dly, m_st, m_irq, m_rd;
  initial begin
    m_cm = 0; m_ie = 0; m_ee = 0; m_dly = 0; m_st = 0; m_irq = 0; m_rd = 0;
  end

  always @(posedge clk) begin
    int a, rd_n, irq_n, st_n;
    if (rst) begin
      m_cm = 0; m_ie = 0; m_ee = 0; m_dly = 0; m_st = 0; m_irq = 0; m_rd = 0;
    end else begin
      a = int'(reg_addr);
      case (a)
        'h01: rd_n = (m_cm & 'h28) | (active_ctrl_in ? 'h02 : 0);
        'h03: rd_n = m_ie;
        'h05: rd_n = m_ee;
        'h04: rd_n = m_st | (chip_irq ? 1 : 0) | (m_irq ? 2 : 0);
        default: rd_n = 0;
      endcase
      irq_n = 0;
      if ((m_cm & 'h20) != 0) begin
        if (chip_irq && (m_ie & 'h01) != 0) irq_n = 1;
        if ((m_st & m_ie & 'h30) != 0)      irq_n = 1;
      end
      st_n = m_st;
      if (reg_wr && a == 'h04) st_n = st_n & ~(int'(reg_wdata) & 'h30);
      if (bufend_pulse && (m_ee & 'h10) != 0) st_n = st_n | 'h10;
      if (tcount_pulse && (m_ee & 'h20) != 0) st_n = st_n | 'h20;
      if (reg_wr && a == 'h01) m_cm  = int'(reg_wdata) & 'h28;
      if (reg_wr && a == 'h03) m_ie  = int'(reg_wdata) & 'h31;
      if (reg_wr && a == 'h05) m_ee  = int'(reg_wdata) & 'h30;
      if (reg_wr && a == 'h19) m_dly = int'(reg_wdata);
      m_st = st_n; m_irq = irq_n; m_rd = rd_n;
    end
  end

  // every clock: compare outputs with the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R6 host_irq", int'(host_irq), m_irq);
      check("R10 reg_rdata", int'(reg_rdata), m_rd);
      check("R8 sys_ctrl_sel", int'(sys_ctrl_sel), (m_cm >> 3) & 1);
      check("R9 bus_delay", int'(bus_delay), m_dly);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 5'(a);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic pulse_be();
    @(negedge clk); bufend_pulse = 1'b1;
    @(negedge clk); bufend_pulse = 1'b0;
  endtask

  task automatic pulse_tc();
    @(negedge clk); tcount_pulse = 1'b1;
    @(negedge clk); tcount_pulse = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1 host_irq", int'(host_irq), 0);
    rd('h01, v); check("R1 card mode", v, 0);
    rd('h03, v); check("R1 irq enable", v, 0);
    rd('h05, v); check("R1 event enable", v, 0);
    rd('h04, v); check("R1 status", v, 0);
    check("R1 bus_delay", int'(bus_delay), 0);

    // R2: pulses ignored while event enable is off
    pulse_be(); pulse_tc();
    rd('h04, v); check("R2 disabled events", v, 'h00);
    wr('h05, 'h30);
    pulse_be();
    rd('h04, v); check("R2 buffer end latched", v, 'h10);
    pulse_tc();
    rd('h04, v); check("R2 both latched", v, 'h30);

    // R3: write-one-to-clear, zero has no effect
    wr('h04, 'h00);
    rd('h04, v); check("R3 zero write", v, 'h30);
    wr('h04, 'h10);
    rd('h04, v); check("R3 clear buffer end", v, 'h20);
    // R5: writes to bits 0 and 1 ignored
    wr('h04, 'h03);
    rd('h04, v); check("R5 read-only bits", v, 'h20);

    // R4: clear and pulse in one cycle, new event wins
    wr('h04, 'h20);
    rd('h04, v); check("R3 clear terminal count", v, 'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h04; reg_wdata = 8'h20; tcount_pulse = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tcount_pulse = 1'b0;
    rd('h04, v); check("R4 set wins", v, 'h20);
    wr('h04, 'h30);

    // R5/R7/R6: controller request path
    chip_irq = 1'b1;
    rd('h04, v); check("R5 live chip bit", v, 'h01);
    wr('h03, 'h01);
    tick(); check("R7 gie off", int'(host_irq), 0);
    wr('h01, 'h20);
    tick(); check("R6 chip irq asserted", int'(host_irq), 1);
    rd('h04, v); check("R5 summary bit", v, 'h03);
    chip_irq = 1'b0;
    tick(); tick(); check("R6 chip irq released", int'(host_irq), 0);

    // R6: buffer-end path, terminal count masked by its enable
    wr('h03, 'h10);
    pulse_be();
    tick(); check("R6 buffer end irq", int'(host_irq), 1);
    wr('h04, 'h10);
    tick(); check("R6 cleared irq", int'(host_irq), 0);
    pulse_tc();
    tick(); check("R6 masked terminal count", int'(host_irq), 0);
    wr('h03, 'h20);
    tick(); check("R6 terminal count irq", int'(host_irq), 1);
    wr('h01, 'h00);
    tick(); check("R7 gie removed", int'(host_irq), 0);
    wr('h04, 'h30);

    // R8: card mode bits, unimplemented bits read 0
    wr('h01, 'hFF);
    rd('h01, v); check("R8 card mode readback", v, 'h28);
    check("R8 sys_ctrl_sel", int'(sys_ctrl_sel), 1);
    active_ctrl_in = 1'b1;
    rd('h01, v); check("R8 active controller", v, 'h2A);
    active_ctrl_in = 1'b0;
    wr('h03, 'hFF);
    rd('h03, v); check("R8 irq enable mask", v, 'h31);
    wr('h05, 'hFF);
    rd('h05, v); check("R8 event enable mask", v, 'h30);
    wr('h01, 'h00);

    // R9: delay register
    wr('h19, 'h7F);
    check("R9 delay value", int'(bus_delay), 'h7F);
    rd('h19, v); check("R9 write-only read", v, 0);
    wr('h19, 'hFF);
    check("R9 delay max", int'(bus_delay), 'hFF);
    rd('h1F, v); check("R9 unused address", v, 0);

    // R1: reset again with state present
    pulse_be();
    @(negedge clk); rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    rd('h04, v); check("R1 status after reset", v, 0);
    check("R1 delay after reset", int'(bus_delay), 0);

    tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule